// File: doc/BRIEF.md
# Single-Channel Cycle-Stealing Transfer Engine

This block is one transfer channel that copies a programmed number of words from a source address to a destination address over a shared system bus. It runs in one of two modes. In peripheral mode the source is a fixed data register inside a device, and each word is started by a request line from that device. In memory-to-memory mode the block needs no request: software starts it with a start bit, and both addresses walk forward.

The block does not hold the bus for the whole transfer. Before each word it raises a bus request and waits for a grant. While granted it does one read and one write, then releases the request so the processor can use the bus between words.

Two sticky status flags report progress. One marks the halfway point and one marks the end of the transfer. Each flag drives the interrupt line only when its enable bit is set. Software clears a flag by writing a one to it. The channel turns its own enable bit off when the transfer finishes.

Top module: `dma_channel`

## Requirements
- R1: After reset `br`, `bus_rd`, `bus_we`, `per_ack` and `irq` are low, and the control and status registers read as zero.
- R2: In peripheral mode, while enabled with words remaining, each high `per_req` moves exactly one word. The channel reads the word from the source address, pulses `per_ack` during that read, and writes the word to the destination address.
- R3: The destination address goes up by one after every word. In peripheral mode the source address does not change.
- R4: `br` is raised before every word. No bus read or write happens without `bg`. `br` drops in the cycle after the write, so there is exactly one rise of `br` per word.
- R5: The half flag (status bit 0) is set when the number of words moved reaches floor(count/2), and only when that value is nonzero. It drives `irq` only when the half enable (control bit 3) is set.
- R6: After the last word, the done flag (status bit 1) is set and the enable bit (control bit 0) clears itself. The done flag drives `irq` only when the done enable (control bit 4) is set.
- R7: Writing 1 to a status bit clears that flag, and writing 0 leaves it unchanged. `irq` is the OR of every flag whose enable is set, so it also follows later changes to the enable bits.
- R8: In memory-to-memory mode (control bit 1) nothing moves until a control write with the start bit (bit 2) set while enabled. Words then move back to back without `per_req`, and the source and destination addresses both go up by one per word.
- R9: A count of zero completes as soon as the channel is enabled (or started). It sets only the done flag and never raises `br`.
- R10: `per_req` has no effect while the enable bit is 0. No bus request is made, no memory is written, and the remaining count does not change.
- R11: Register offsets on `cpu_addr`:
  - 0 is the source address.
  - 1 is the destination address.
  - 2 is the count. Writing it loads the count, and reading it returns the words still to move.
  - 3 is control. Bit 0 is enable, bit 1 is memory-to-memory mode, bit 2 is start (write only, reads 0), bit 3 is the half enable and bit 4 is the done enable.
  - 4 is status. Bit 0 is the half flag and bit 1 is the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 3 | Register offset |
| cpu_wdata | input | DW | Register write data |
| cpu_rdata | output | DW | Register read data (combinational) |
| irq | output | 1 | Interrupt, OR of enabled set flags |
| br | output | 1 | Bus request |
| bg | input | 1 | Bus grant |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Bus read strobe, data sampled at clock edge |
| bus_we | output | 1 | Bus write strobe |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data |
| per_req | input | 1 | Peripheral word request |
| per_ack | output | 1 | Peripheral read acknowledge |

## Verification
The bench builds the block with its defaults: 16-bit addresses, data and count. This leaves room for a peripheral data register at 0xF000, clear of a small memory window, so a source address that wrongly increments shows up as a misdirected read. The counts used are 0, 2, 4 and 5. Together they cover the no-bus completion, an even halfway point, an odd count where the halfway point rounds down, and the case where the halfway and final words fall close together. A grant delayed by two cycles keeps the request-to-grant wait visible on every word.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RD, ST_WR} eng_state_t;

  localparam logic [2:0] OFS_SRC  = 3'd0;
  localparam logic [2:0] OFS_DST  = 3'd1;
  localparam logic [2:0] OFS_CNT  = 3'd2;
  localparam logic [2:0] OFS_CTRL = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd4;

  localparam int B_EN   = 0;
  localparam int B_M2M  = 1;
  localparam int B_GO   = 2;
  localparam int B_HTIE = 3;
  localparam int B_TCIE = 4;
  localparam int B_HT   = 0;
  localparam int B_TC   = 1;

  // word count at which the half flag fires
  function automatic int unsigned half_mark(input int unsigned total);
    return total >> 1;
  endfunction

  // true when the word that leaves 'left_after' remaining reaches the mark
  function automatic logic half_hit(input int unsigned total,
                                    input int unsigned left_after);
    return (half_mark(total) != 0) && ((total - left_after) == half_mark(total));
  endfunction
endpackage

// File: rtl/dma_ch_engine.sv
module dma_ch_engine
  import dma_ch_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          m2m,
  input  logic          go,
  input  logic [CW-1:0] total,
  input  logic          ld_src,
  input  logic          ld_dst,
  input  logic          ld_cnt,
  input  logic [DW-1:0] ld_val,
  input  logic          per_req,
  input  logic          bg,
  input  logic [DW-1:0] bus_rdata,
  output logic          br,
  output logic          bus_rd,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          per_ack,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] rem_o,
  output logic          ev_word_done,
  output logic          ev_half,
  output logic          ev_complete
);
  eng_state_t    st_q, st_d;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] rem_q;
  logic [DW-1:0] buf_q;
  logic          armed, start_word;

  always_comb begin
    armed        = en && (m2m ? go : 1'b1);
    start_word   = armed && (rem_q != '0) && (m2m || per_req);
    ev_complete  = (st_q == ST_IDLE) && armed && (rem_q == '0);
    ev_word_done = (st_q == ST_WR);
    ev_half      = ev_word_done && half_hit(32'(total), 32'(rem_q) - 32'd1);
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_word) st_d = ST_REQ;
      ST_REQ:  if (bg) st_d = ST_RD;
      ST_RD:   st_d = ST_WR;
      ST_WR:   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      src_q <= '0;
      dst_q <= '0;
      rem_q <= '0;
      buf_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_RD) buf_q <= bus_rdata;
      if (ld_src)                   src_q <= AW'(ld_val);
      else if (ev_word_done && m2m) src_q <= src_q + 1'b1;
      if (ld_dst)            dst_q <= AW'(ld_val);
      else if (ev_word_done) dst_q <= dst_q + 1'b1;
      if (ld_cnt)            rem_q <= CW'(ld_val);
      else if (ev_word_done) rem_q <= rem_q - 1'b1;
    end
  end

  assign br        = (st_q != ST_IDLE);
  assign bus_rd    = (st_q == ST_RD);
  assign bus_we    = (st_q == ST_WR);
  assign bus_addr  = (st_q == ST_WR) ? dst_q : src_q;
  assign bus_wdata = buf_q;
  assign per_ack   = (st_q == ST_RD) && !m2m;
  assign src_o     = src_q;
  assign dst_o     = dst_q;
  assign rem_o     = rem_q;

  // R4
  br_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_word_done |=> !br);
  // R4
  br_rise_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(br) |-> $past(en));
  // R3
  dst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_word_done && !ld_dst) |=> (dst_q == $past(dst_q) + 1'b1));
  // R3
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_word_done && !m2m && !ld_src) |=> $stable(src_q));
endmodule

// File: rtl/dma_ch_regs.sv
module dma_ch_regs
  import dma_ch_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_we,
  input  logic [2:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] rem_i,
  input  logic          ev_half,
  input  logic          ev_complete,
  output logic          en,
  output logic          m2m,
  output logic          go,
  output logic [CW-1:0] total,
  output logic          ld_src,
  output logic          ld_dst,
  output logic          ld_cnt,
  output logic          irq
);
  logic en_q, m2m_q, go_q, htie_q, tcie_q, ht_q, tc_q;
  logic [CW-1:0] total_q;
  logic wr_ctrl, wr_stat;

  assign ld_src  = cpu_we && (cpu_addr == OFS_SRC);
  assign ld_dst  = cpu_we && (cpu_addr == OFS_DST);
  assign ld_cnt  = cpu_we && (cpu_addr == OFS_CNT);
  assign wr_ctrl = cpu_we && (cpu_addr == OFS_CTRL);
  assign wr_stat = cpu_we && (cpu_addr == OFS_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; m2m_q <= 1'b0; go_q <= 1'b0;
      htie_q <= 1'b0; tcie_q <= 1'b0;
      ht_q <= 1'b0; tc_q <= 1'b0;
      total_q <= '0;
    end else begin
      if (ld_cnt) total_q <= CW'(cpu_wdata);
      if (wr_ctrl) begin
        en_q   <= cpu_wdata[B_EN];
        m2m_q  <= cpu_wdata[B_M2M];
        go_q   <= cpu_wdata[B_GO] && cpu_wdata[B_M2M] && cpu_wdata[B_EN];
        htie_q <= cpu_wdata[B_HTIE];
        tcie_q <= cpu_wdata[B_TCIE];
      end
      if (ev_complete) begin
        en_q <= 1'b0;
        go_q <= 1'b0;
      end
      ht_q <= ev_half     || (ht_q && !(wr_stat && cpu_wdata[B_HT]));
      tc_q <= ev_complete || (tc_q && !(wr_stat && cpu_wdata[B_TC]));
    end
  end

  always_comb begin
    unique case (cpu_addr)
      OFS_SRC:  cpu_rdata = DW'(src_i);
      OFS_DST:  cpu_rdata = DW'(dst_i);
      OFS_CNT:  cpu_rdata = DW'(rem_i);
      OFS_CTRL: cpu_rdata = DW'({tcie_q, htie_q, 1'b0, m2m_q, en_q});
      OFS_STAT: cpu_rdata = DW'({tc_q, ht_q});
      default:  cpu_rdata = '0;
    endcase
  end

  assign en    = en_q;
  assign m2m   = m2m_q;
  assign go    = go_q;
  assign total = total_q;
  assign irq   = (ht_q && htie_q) || (tc_q && tcie_q);

  // R6
  done_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_complete |=> (!en_q && tc_q));
  // R5
  half_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_half |=> ht_q);
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_ch_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_we,
  input  logic [2:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          irq,
  output logic          br,
  input  logic          bg,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_we,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          per_req,
  output logic          per_ack
);
  logic          en, m2m, go, ld_src, ld_dst, ld_cnt;
  logic [CW-1:0] total, rem;
  logic [AW-1:0] src, dst;
  logic          ev_word_done, ev_half, ev_complete;

  dma_ch_regs #(.AW(AW), .DW(DW), .CW(CW)) regs_i (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .src_i(src), .dst_i(dst), .rem_i(rem),
    .ev_half(ev_half), .ev_complete(ev_complete),
    .en(en), .m2m(m2m), .go(go), .total(total),
    .ld_src(ld_src), .ld_dst(ld_dst), .ld_cnt(ld_cnt), .irq(irq)
  );

  dma_ch_engine #(.AW(AW), .DW(DW), .CW(CW)) eng_i (
    .clk(clk), .rst_n(rst_n), .en(en), .m2m(m2m), .go(go), .total(total),
    .ld_src(ld_src), .ld_dst(ld_dst), .ld_cnt(ld_cnt), .ld_val(cpu_wdata),
    .per_req(per_req), .bg(bg), .bus_rdata(bus_rdata),
    .br(br), .bus_rd(bus_rd), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .per_ack(per_ack),
    .src_o(src), .dst_o(dst), .rem_o(rem),
    .ev_word_done(ev_word_done), .ev_half(ev_half), .ev_complete(ev_complete)
  );

  // R9
  zero_no_br_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_complete && !br) |=> !br);
endmodule

// File: tb/dma_channel_tb_top.sv
`timescale 1ns/1ps
module dma_channel_tb_top;
  localparam logic [15:0] PER_ADDR = 16'hF000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [2:0]  cpu_addr = 3'd0;
  logic [15:0] cpu_wdata = 16'h0;
  logic [15:0] cpu_rdata;
  logic        irq, br, bus_rd, bus_we, per_ack;
  logic        bg = 1'b0, bg_dly = 1'b0;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic        per_req = 1'b0;
  logic [15:0] per_data = 16'h0;
  logic [15:0] mem [0:255];

  int total = 0, bad = 0, br_rises = 0;
  bit br_prev = 1'b0, mode_per = 1'b1, done = 1'b0;
  logic [15:0] exp_a[$], exp_d[$];

  always #2.5 clk = ~clk;

  dma_channel dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq), .br(br), .bg(bg),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .per_req(per_req), .per_ack(per_ack)
  );

  // memory and peripheral data register
  assign bus_rdata = (bus_addr == PER_ADDR) ? per_data : mem[bus_addr[7:0]];
  always @(posedge clk) if (bus_we && bus_addr != PER_ADDR) mem[bus_addr[7:0]] <= bus_wdata;

  // grant arrives two cycles after request, drops with it
  always @(posedge clk) begin
    bg_dly <= br;
    bg     <= br & bg_dly;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop and bus rules
  always @(negedge clk) begin
    if (rst_n) begin
      if ((bus_rd || bus_we) && !bg) chk(1'b0, "R4 bus access without grant", 32'(bus_addr), 32'hFFFF);
      if (bus_rd && mode_per && bus_addr != PER_ADDR)
        chk(1'b0, "R3 peripheral source moved", 32'(bus_addr), 32'(PER_ADDR));
      if (bus_we) begin
        if (exp_a.size() == 0) chk(1'b0, "R2 unexpected write", 32'(bus_addr), 32'hFFFF);
        else begin
          logic [15:0] ea, ed;
          ea = exp_a.pop_front();
          ed = exp_d.pop_front();
          chk(bus_addr == ea, "R3 write address", 32'(bus_addr), 32'(ea));
          chk(bus_wdata == ed, "R2 write data", 32'(bus_wdata), 32'(ed));
        end
      end
      if (br && !br_prev) br_rises++;
      br_prev = br;
    end
  end

  task automatic cpu_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  // driver: one peripheral word
  task automatic per_word(input logic [15:0] data, input logic [15:0] dst);
    int k;
    @(negedge clk);
    per_data = data;
    exp_a.push_back(dst);
    exp_d.push_back(data);
    per_req = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!per_ack && k < 50);
    per_req = 1'b0;
    while (br) @(negedge clk);
  endtask

  task automatic wait_done();
    logic [15:0] v;
    for (int k = 0; k < 200; k++) begin
      cpu_read(3'd4, v);
      if (v[1]) break;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    summary();
  end

  initial begin
    logic [15:0] v;
    int r0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!br && !bus_rd && !bus_we && !per_ack, "R1 bus idle after reset", 32'(br), 0);
    chk(!irq, "R1 irq after reset", 32'(irq), 0);
    rst_n = 1'b1;
    cpu_read(3'd3, v); chk(v == 16'h0, "R1 control after reset", 32'(v), 0);
    cpu_read(3'd4, v); chk(v == 16'h0, "R1 status after reset", 32'(v), 0);

    // R2 R3 R4 R5 R6: peripheral mode, 4 words, both interrupt enables
    mode_per = 1'b1;
    cpu_write(3'd0, PER_ADDR);
    cpu_write(3'd1, 16'h0020);
    cpu_write(3'd2, 16'd4);
    cpu_write(3'd3, 16'h0019);
    for (int i = 0; i < 4; i++) begin
      per_word(16'hA000 + 16'(i), 16'h0020 + 16'(i));
      if (i == 0) begin
        cpu_read(3'd4, v); chk(v == 16'h0, "R5 no half after 1 of 4", 32'(v), 0);
      end
      if (i == 1) begin
        cpu_read(3'd4, v); chk(v == 16'h1, "R5 half flag after 2 of 4", 32'(v), 1);
        chk(irq, "R5 half irq enabled", 32'(irq), 1);
      end
    end
    repeat (3) @(negedge clk);
    cpu_read(3'd4, v); chk(v == 16'h3, "R6 done flag", 32'(v), 3);
    cpu_read(3'd3, v); chk(v == 16'h0018, "R6 enable self-clears", 32'(v), 32'h18);
    cpu_read(3'd2, v); chk(v == 16'h0, "R11 remaining count", 32'(v), 0);
    cpu_read(3'd1, v); chk(v == 16'h0024, "R3 destination advanced", 32'(v), 32'h24);
    cpu_read(3'd0, v); chk(v == PER_ADDR, "R3 source fixed", 32'(v), 32'(PER_ADDR));
    chk(br_rises == 4, "R4 one request per word", 32'(br_rises), 4);
    chk(exp_a.size() == 0, "R2 all words written", 32'(exp_a.size()), 0);

    // R7 write-one-to-clear
    cpu_write(3'd4, 16'h0001);
    cpu_read(3'd4, v); chk(v == 16'h2, "R7 clear half only", 32'(v), 2);
    chk(irq, "R7 irq from done flag", 32'(irq), 1);
    cpu_write(3'd4, 16'h0002);
    cpu_read(3'd4, v); chk(v == 16'h0, "R7 clear done", 32'(v), 0);
    chk(!irq, "R7 irq low when clear", 32'(irq), 0);

    // R5 R6 gating: enables off
    cpu_write(3'd1, 16'h0030);
    cpu_write(3'd2, 16'd2);
    cpu_write(3'd3, 16'h0001);
    per_word(16'hB001, 16'h0030);
    per_word(16'hB002, 16'h0031);
    repeat (3) @(negedge clk);
    cpu_read(3'd4, v); chk(v == 16'h3, "R6 flags set with enables off", 32'(v), 3);
    chk(!irq, "R5 R6 irq gated", 32'(irq), 0);
    cpu_write(3'd3, 16'h0010);
    chk(irq, "R7 irq follows done enable", 32'(irq), 1);
    cpu_write(3'd4, 16'h0003);
    chk(!irq, "R7 irq after clear", 32'(irq), 0);

    // R8 memory to memory
    mode_per = 1'b0;
    for (int i = 0; i < 5; i++) mem[8'h40 + i] = 16'hC000 + 16'(i * 3);
    cpu_write(3'd0, 16'h0040);
    cpu_write(3'd1, 16'h0060);
    cpu_write(3'd2, 16'd5);
    r0 = br_rises;
    cpu_write(3'd3, 16'h0003);
    repeat (10) @(negedge clk);
    chk(br_rises == r0, "R8 no move before start", 32'(br_rises), 32'(r0));
    for (int i = 0; i < 5; i++) begin
      exp_a.push_back(16'h0060 + 16'(i));
      exp_d.push_back(16'hC000 + 16'(i * 3));
    end
    cpu_write(3'd3, 16'h0017);
    wait_done();
    repeat (2) @(negedge clk);
    cpu_read(3'd4, v); chk(v == 16'h3, "R8 R5 flags after 5 words", 32'(v), 3);
    for (int i = 0; i < 5; i++)
      chk(mem[8'h60 + i] == 16'hC000 + 16'(i * 3), "R8 copied word",
          32'(mem[8'h60 + i]), 32'(16'hC000 + 16'(i * 3)));
    cpu_read(3'd0, v); chk(v == 16'h0045, "R8 source advanced", 32'(v), 32'h45);
    cpu_read(3'd1, v); chk(v == 16'h0065, "R8 destination advanced", 32'(v), 32'h65);
    chk(br_rises == r0 + 5, "R4 m2m requests per word", 32'(br_rises), 32'(r0 + 5));
    chk(exp_a.size() == 0, "R8 all words written", 32'(exp_a.size()), 0);
    cpu_write(3'd4, 16'h0003);

    // R9 zero count
    mode_per = 1'b1;
    cpu_write(3'd1, 16'h0070);
    cpu_write(3'd2, 16'd0);
    r0 = br_rises;
    cpu_write(3'd3, 16'h0019);
    repeat (5) @(negedge clk);
    cpu_read(3'd4, v); chk(v == 16'h2, "R9 only done flag", 32'(v), 2);
    chk(irq, "R9 irq from done", 32'(irq), 1);
    chk(br_rises == r0, "R9 no bus request", 32'(br_rises), 32'(r0));
    cpu_read(3'd3, v); chk(v == 16'h0018, "R9 enable cleared", 32'(v), 32'h18);
    cpu_write(3'd4, 16'h0003);

    // R10 requests while disabled
    cpu_write(3'd2, 16'd3);
    cpu_write(3'd3, 16'h0000);
    @(negedge clk);
    per_req = 1'b1;
    repeat (10) @(negedge clk);
    per_req = 1'b0;
    chk(br_rises == r0, "R10 no request while disabled", 32'(br_rises), 32'(r0));
    cpu_read(3'd2, v); chk(v == 16'd3, "R10 count untouched", 32'(v), 3);
    chk(mem[8'h70] == 16'h0, "R10 memory untouched", 32'(mem[8'h70]), 0);
    chk(exp_a.size() == 0, "R10 no stray writes", 32'(exp_a.size()), 0);

    repeat (5) @(negedge clk);
    summary();
  end
endmodule